// File: doc/BRIEF.md
# Telecom Timing Mode Controller

This block turns a 4-bit mode-select word into the control settings for a timing generator built from two digital phase-locked loops. It sets the operating mode of the first loop: normal, or one of two fixed-ratio divide modes. It picks the reference that the second loop locks to. It also decides whether a shared bidirectional frame pin is driven or left as an input.

In the two divide modes, a synchronous modulo counter runs on the rising edges of the slow line clock input `cv_in`. The counter emits a one-cycle pulse each time it wraps, and that pulse train serves as the first loop's 8 kHz signal toward the second loop. The mode word passes through two register stages before it is decoded, so every decoded output changes only on a clock edge. The loops, the pads and clock synthesis are outside this block.

Top module: `timing_mode_ctrl`

## Requirements
- R1: While `rst_n` is low and directly after it, `loop1_mode_o` is 0, `ref_sel_o` is 0, `pin_oe_o` is 0 and `div_pulse_o` is 0.
- R2: `mode_sel_i[3:0]` is read as {M0,M1,M2,M3}, with M0 in bit 3. `loop1_mode_o` decodes {M0,M1}: 00 and 10 give 0 (normal), 01 gives 1 (divide by 193), and 11 gives 2 (divide by 256).
- R3: When {M2,M3} is 00, `ref_sel_o` is 0 (external clock with frame pulse). When {M2,M3} is 01 or 10, it is 1 (external clock only). In these cases the value does not depend on {M0,M1}.
- R4: When {M2,M3} is 11, `ref_sel_o` depends on {M0,M1}. 00 gives 2 (external 8 kHz input). 01 and 11 give 3 (first loop's internal 8 kHz). 10 gives 4 (shared pin as a 16 kHz free-run reference).
- R5: `pin_oe_o` is 1 exactly when M2 is 1 and the mode is not free-run (mode word 1011). In every other mode the pin is an input.
- R6: A change on `mode_sel_i` is ignored for two clock edges. The decoded outputs take the new value on the third rising edge after the change.
- R7: In divide-by-193 mode, consecutive `div_pulse_o` pulses are exactly 193 rising edges of `cv_in` apart.
- R8: In divide-by-256 mode, consecutive `div_pulse_o` pulses are exactly 256 rising edges of `cv_in` apart.
- R9: `div_pulse_o` stays 0 in normal mode, and it is never high on two clock cycles in a row.
- R10: On entry to a divide mode the counter starts from zero. The first pulse therefore follows exactly N rising edges of `cv_in`, counted from the first edge after the new mode is decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_sel_i | input | 4 | Mode word {M0,M1,M2,M3}, asynchronous to clk |
| cv_in | input | 1 | Slow line clock to be divided, sampled in clk |
| loop1_mode_o | output | 2 | First loop mode: 0 normal, 1 divide by 193, 2 divide by 256 |
| ref_sel_o | output | 3 | Second loop reference code, 0 to 4 as in R3 and R4 |
| pin_oe_o | output | 1 | Output enable for the shared frame pin |
| div_pulse_o | output | 1 | One-cycle pulse on each divider wrap |

## Verification
The decoded outputs are due on the third rising edge after the mode word changes. The bench drives the word on a falling edge and reads the outputs on falling edges: after two edges it expects the old value and after three the new one, and in the full 16-mode sweep it waits four edges before reading. A divider pulse appears about three clock cycles after the `cv_in` edge that completes a count. The bench holds each `cv_in` level for four cycles and counts the edges it has driven up to the cycle where the pulse is seen, so every pulse is attributed to the correct edge.

// File: rtl/tmc_pkg.sv
// Package: shared encodings for the timing mode controller.
// Assumes: the codes below are the values seen on the top-level ports.
package tmc_pkg;
    localparam int MODE_W = 4;

    typedef enum logic [1:0] {
        L1_NORMAL = 2'd0,
        L1_DIV_A  = 2'd1,
        L1_DIV_B  = 2'd2
    } loop1_mode_t;

    typedef enum logic [2:0] {
        REF_CLK_FRAME = 3'd0,
        REF_CLK_ONLY  = 3'd1,
        REF_EXT_8K    = 3'd2,
        REF_LOOP1_8K  = 3'd3,
        REF_PIN_16K   = 3'd4
    } ref_src_t;
endpackage

// File: rtl/tmc_sync.sv
// Module: multi-stage register chain that brings an asynchronous bus into clk.
// Assumes: bus bits that change together are quasi-static (mode straps or a slow clock).
module tmc_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Shift one stage per clock, cleared by reset.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else if (g == 0) stage_q[g] <= d_i;
                else stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/tmc_mode_decode.sv
// Module: registered decode of the synchronised mode word into loop-1 mode,
// loop-2 reference code and shared-pin direction.
// Assumes: mode_i is already synchronous to clk; bit 3 is M0, bit 0 is M3.
module tmc_mode_decode
    import tmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_i,
    output loop1_mode_t       loop1_mode_o,
    output ref_src_t          ref_sel_o,
    output logic              pin_oe_o
);
    logic [1:0]  l1_bits;
    logic [1:0]  l2_bits;
    loop1_mode_t l1_next;
    ref_src_t    ref_next;
    logic        free_run;
    logic        oe_next;

    assign l1_bits = mode_i[3:2];
    assign l2_bits = mode_i[1:0];

    // First-loop mode from the two upper mode bits.
    always_comb begin
        unique case (l1_bits)
            2'b01:   l1_next = L1_DIV_A;
            2'b11:   l1_next = L1_DIV_B;
            default: l1_next = L1_NORMAL;
        endcase
    end

    // Second-loop reference; the upper bits matter only when both lower bits are set.
    always_comb begin
        free_run = 1'b0;
        unique case (l2_bits)
            2'b00: ref_next = REF_CLK_FRAME;
            2'b01,
            2'b10: ref_next = REF_CLK_ONLY;
            default: begin
                unique case (l1_bits)
                    2'b00: ref_next = REF_EXT_8K;
                    2'b10: begin
                        ref_next = REF_PIN_16K;
                        free_run = 1'b1;
                    end
                    default: ref_next = REF_LOOP1_8K;
                endcase
            end
        endcase
    end

    // The pin drives a frame pulse when M2 is set, except when it is the free-run input.
    assign oe_next = mode_i[1] & ~free_run;

    // Register all decoded outputs so they move only on a clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loop1_mode_o <= L1_NORMAL;
            ref_sel_o    <= REF_CLK_FRAME;
            pin_oe_o     <= 1'b0;
        end else begin
            loop1_mode_o <= l1_next;
            ref_sel_o    <= ref_next;
            pin_oe_o     <= oe_next;
        end
    end
endmodule

// File: rtl/tmc_mod_divider.sv
// Module: synchronous modulo-DIV counter of input ticks with a one-cycle wrap pulse.
// Assumes: tick_i is a single-cycle strobe; counter is held at zero while en_i is low.
module tmc_mod_divider #(
    parameter int DIV = 193
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic tick_i,
    output logic pulse_o
);
    localparam int CW = $clog2(DIV + 1);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;
    logic          wrap;

    assign wrap = en_i && tick_i && (cnt_q == LAST);

    // Count ticks while enabled; clear whenever disabled so entry starts at zero.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) cnt_q <= '0;
        else if (tick_i) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end

    // Register the wrap strobe as the output pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_o <= 1'b0;
        else pulse_o <= wrap;
    end
endmodule

// File: rtl/timing_mode_ctrl.sv
// Module: top of the timing mode controller. Synchronises the mode word and the
// slow line clock, decodes modes, and runs the two fixed-ratio dividers.
// Assumes: cv_in is much slower than clk (each level held for at least 3 cycles).
module timing_mode_ctrl
    import tmc_pkg::*;
#(
    parameter int DIV_A       = 193,
    parameter int DIV_B       = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] mode_sel_i,
    input  logic       cv_in,
    output logic [1:0] loop1_mode_o,
    output logic [2:0] ref_sel_o,
    output logic       pin_oe_o,
    output logic       div_pulse_o
);
    localparam int NDIV = 2;
    localparam int DIV_TAB [NDIV] = '{DIV_A, DIV_B};

    logic [MODE_W-1:0] mode_sync;
    logic [0:0]        cv_sync;
    logic              cv_prev;
    logic              cv_rise;
    loop1_mode_t       l1_mode;
    ref_src_t          ref_sel;
    logic [NDIV-1:0]   div_en;
    logic [NDIV-1:0]   div_pulse;

    tmc_sync #(.W(MODE_W), .STAGES(SYNC_STAGES)) u_mode_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (mode_sel_i),
        .q_o   (mode_sync)
    );

    tmc_sync #(.W(1), .STAGES(SYNC_STAGES)) u_cv_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (cv_in),
        .q_o   (cv_sync)
    );

    // Hold the previous synchronised line-clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cv_prev <= 1'b0;
        else cv_prev <= cv_sync[0];
    end

    assign cv_rise = cv_sync[0] & ~cv_prev;

    tmc_mode_decode u_decode (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_i       (mode_sync),
        .loop1_mode_o (l1_mode),
        .ref_sel_o    (ref_sel),
        .pin_oe_o     (pin_oe_o)
    );

    genvar g;
    generate
        for (g = 0; g < NDIV; g++) begin : g_div
            assign div_en[g] = (l1_mode == loop1_mode_t'(g + 1));
            tmc_mod_divider #(.DIV(DIV_TAB[g])) u_div (
                .clk     (clk),
                .rst_n   (rst_n),
                .en_i    (div_en[g]),
                .tick_i  (cv_rise),
                .pulse_o (div_pulse[g])
            );
        end
    endgenerate

    assign div_pulse_o  = |div_pulse;
    assign loop1_mode_o = l1_mode;
    assign ref_sel_o    = ref_sel;
endmodule

// File: rtl/timing_mode_ctrl_chk.sv
// Module: property checker for timing_mode_ctrl, attached by bind.
// Assumes: port encodings of tmc_pkg.
module timing_mode_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] loop1_mode_o,
    input logic [2:0] ref_sel_o,
    input logic       pin_oe_o,
    input logic       div_pulse_o
);
    // R5
    oe_not_in_free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe_o |-> (ref_sel_o != 3'd4));

    // R9
    no_pulse_in_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse_o |-> (loop1_mode_o != 2'd0) || $past(loop1_mode_o) != 2'd0);

    // R9
    single_cycle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse_o |=> !div_pulse_o);

    // R4
    internal_ref_needs_divider_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_sel_o == 3'd3) |-> (loop1_mode_o != 2'd0));

    // R2
    legal_mode_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loop1_mode_o != 2'd3);
endmodule

bind timing_mode_ctrl timing_mode_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .loop1_mode_o (loop1_mode_o),
    .ref_sel_o    (ref_sel_o),
    .pin_oe_o     (pin_oe_o),
    .div_pulse_o  (div_pulse_o)
);

// File: tb/timing_mode_ctrl_tb_top.sv
module timing_mode_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] mode_sel_i = 4'd0;
    logic       cv_in = 1'b0;
    logic [1:0] loop1_mode_o;
    logic [2:0] ref_sel_o;
    logic       pin_oe_o;
    logic       div_pulse_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    timing_mode_ctrl dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_sel_i   (mode_sel_i),
        .cv_in        (cv_in),
        .loop1_mode_o (loop1_mode_o),
        .ref_sel_o    (ref_sel_o),
        .pin_oe_o     (pin_oe_o),
        .div_pulse_o  (div_pulse_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_l1(input logic [3:0] m);
        case (m[3:2])
            2'b01:   return 1;
            2'b11:   return 2;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_ref(input logic [3:0] m);
        int l1 = m[3] * 2 + m[2];
        int l2 = m[1] * 2 + m[0];
        if (l2 == 0) return 0;
        if (l2 != 3) return 1;
        if (l1 == 0) return 2;
        if (l1 == 2) return 4;
        return 3;
    endfunction

    function automatic int exp_oe(input logic [3:0] m);
        return (m[1] == 1'b1 && m != 4'b1011) ? 1 : 0;
    endfunction

    // Drive cv_in for up to max_edges rising edges; return edges counted to each pulse.
    task automatic run_cv(input int max_edges, output int first_gap,
                          output int second_gap, output int pulses);
        int edges = 0;
        first_gap = -1;
        second_gap = -1;
        pulses = 0;
        for (int e = 0; e < max_edges; e++) begin
            cv_in = 1'b1;
            edges++;
            for (int c = 0; c < 4; c++) begin
                @(negedge clk);
                if (div_pulse_o) begin
                    pulses++;
                    if (pulses == 1) first_gap = edges;
                    if (pulses == 2) second_gap = edges;
                    edges = 0;
                end
            end
            cv_in = 1'b0;
            for (int c = 0; c < 4; c++) begin
                @(negedge clk);
                if (div_pulse_o) begin
                    pulses++;
                    if (pulses == 1) first_gap = edges;
                    if (pulses == 2) second_gap = edges;
                    edges = 0;
                end
            end
        end
    endtask

    initial begin
        int g1, g2, np;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 loop1_mode", loop1_mode_o, 0);
        check("R1 ref_sel", ref_sel_o, 0);
        check("R1 pin_oe", pin_oe_o, 0);
        check("R1 div_pulse", div_pulse_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", ref_sel_o, 0);

        // R2 R3 R4 R5: full sweep of all 16 mode words
        for (int m = 0; m < 16; m++) begin
            mode_sel_i = 4'(m);
            repeat (4) @(negedge clk);
            check($sformatf("R2 mode %0d loop1", m), loop1_mode_o, exp_l1(4'(m)));
            check($sformatf("R3/R4 mode %0d ref", m), ref_sel_o, exp_ref(4'(m)));
            check($sformatf("R5 mode %0d oe", m), pin_oe_o, exp_oe(4'(m)));
        end

        // R6: latency of three edges (1111 -> 1011)
        mode_sel_i = 4'b1011;
        repeat (2) @(negedge clk);
        check("R6 old value held", ref_sel_o, 3);
        @(negedge clk);
        check("R6 new value", ref_sel_o, 4);
        check("R6 oe new value", pin_oe_o, 0);

        // R9: no pulses in normal mode
        mode_sel_i = 4'b0011;
        repeat (5) @(negedge clk);
        run_cv(300, g1, g2, np);
        check("R9 normal no pulse", np, 0);

        // R10 R7: divide by 193
        mode_sel_i = 4'b0111;
        repeat (5) @(negedge clk);
        run_cv(193 * 2, g1, g2, np);
        check("R10 first gap 193", g1, 193);
        check("R7 gap 193", g2, 193);
        check("R7 pulse count", np, 2);

        // R10 R8: divide by 256, entered mid-count of the other divider
        mode_sel_i = 4'b1101;
        repeat (5) @(negedge clk);
        run_cv(256 * 2, g1, g2, np);
        check("R10 first gap 256", g1, 256);
        check("R8 gap 256", g2, 256);
        check("R8 pulse count", np, 2);

        // R10: leave mid-count, re-enter divide-by-193, count restarts from zero
        run_cv(100, g1, g2, np);
        mode_sel_i = 4'b0100;
        repeat (5) @(negedge clk);
        run_cv(193, g1, g2, np);
        check("R10 restart gap 193", g1, 193);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_checks++;
                n_fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule